// File: doc/BRIEF.md
# SECDED Error-Correcting Code Path

This block protects a 64-bit data word with an 8-bit check field built from an extended Hamming code. The code corrects any single flipped bit and detects any two flipped bits. The write side encodes incoming data into a 72-bit stored word. It also presents the check field on a dedicated output. The read side takes a 72-bit word as it comes back from storage. It returns corrected data together with one flag for a corrected single error and one flag for a detected double error.

For testing the protection logic, two inputs deliberately corrupt the word on its way out of the encoder. One flips a single bit and the other flips two bits. Encoding and decoding each have their own enable:

- When encoding is off, a caller-supplied check field is used as is.
- When decoding is off, the raw data comes back with both flags quiet.

Both paths register their outputs, so each has one clock of latency. Reset is synchronous and active high.

Top module: `secded_path`

## Requirements
- R1: With `enc_en` high, `wr_word` one clock after the inputs holds `wr_data` in bits [63:0] and seven Hamming checks in bits [70:64]. Codeword positions are numbered from 1, and the data bits fill the positions that are not powers of two, in ascending order. Check bit i is the XOR of the data bits whose position has bit i set. Bit 71 makes the parity of all 72 bits even.
- R2: `check_out` shows the same 8-bit check field that `wr_word[71:64]` carries, in the same cycle.
- R3: A word that is read back unmodified returns its data one clock later, with `err_single` and `err_double` both low.
- R4: A word with exactly one flipped data bit returns the original data, with `err_single` high and `err_double` low.
- R5: A word with exactly one flipped check bit (word bits 64..71) returns its data unchanged, with `err_single` high.
- R6: A word with exactly two flipped bits raises `err_double` with `err_single` low. The data is not corrected, so `rd_data` equals the received bits [63:0].
- R7: With `inj_single` high and `inj_double` low, `wr_word` differs from the clean encoding in word bit 0 only.
- R8: With `inj_double` high, `wr_word` differs from the clean encoding in word bits 0 and 1 exactly, whatever the value of `inj_single`.
- R9: With `enc_en` low, `wr_word[71:64]` and `check_out` both equal `ext_check` as sampled one clock earlier.
- R10: With `dec_en` low, `rd_data` equals `rd_word[63:0]` of one clock earlier, and both error flags are low, even for a corrupted word.
- R11: While `rst` is high, every output is zero on the following clock.
- R12: `err_single` and `err_double` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_en | input | 1 | High: compute the check field; low: use `ext_check` |
| wr_data | input | 64 | Data to encode |
| ext_check | input | 8 | Check field used when encoding is off |
| inj_single | input | 1 | Flip one bit of the written word |
| inj_double | input | 1 | Flip two bits of the written word (takes priority) |
| check_out | output | 8 | Check field of the written word |
| wr_word | output | 72 | Encoded word, to be written to storage |
| dec_en | input | 1 | High: check and correct; low: pass the raw data |
| rd_word | input | 72 | Word read back from storage |
| rd_data | output | 64 | Corrected (or raw) data |
| err_single | output | 1 | A single-bit error was corrected |
| err_double | output | 1 | An uncorrectable two-bit error was detected |

## Verification
A wrong check mask or a wrong syndrome-to-position map cannot hide. It shows at the ports one clock after the word is presented: either as a mismatched `check_out`, or as a wrong corrected bit and a flag in the wrong state. For this reason the bench flips every one of the 72 word positions in turn, and a single misrouted correction line is enough to produce a failure. A swapped flag rule shows up as a flag mismatch in the same cycle as the double-flip and check-bit cases. A broken injection or bypass path shows up in the bit difference of `wr_word` after a single clock.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of Hamming check bits needed for dw data bits (parity bit excluded).
  function automatic int ham_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position (1-based) of data bit d: skip positions that are powers of two.
  function automatic int data_pos(input int d);
    int cnt;
    cnt = -1;
    for (int p = 1; p < 1024; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == d) return p;
      end
    end
    return 0;
  endfunction

  // Data bits covered by Hamming check i, for a dw-bit word (dw <= 256).
  function automatic logic [255:0] ham_mask(input int i, input int dw);
    logic [255:0] m;
    m = '0;
    for (int d = 0; d < dw; d++) begin
      if (((data_pos(d) >> i) & 1) == 1) m[d] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = ham_bits(DATA_W),
  parameter int CHK_W  = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);

  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_ham
    localparam logic [255:0] MSK = ham_mask(i, DATA_W);
    assign ham[i] = ^(data_i & MSK[DATA_W-1:0]);
  end

  // overall even parity across data and Hamming checks
  assign check_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/secded_injector.sv
module secded_injector #(
  parameter int WORD_W = 72,
  parameter int BIT_A  = 0,
  parameter int BIT_B  = 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              inj_single_i,
  input  logic              inj_double_i,
  output logic [WORD_W-1:0] word_o
);

  localparam logic [WORD_W-1:0] ONE_MASK = WORD_W'(1) << BIT_A;
  localparam logic [WORD_W-1:0] TWO_MASK = ONE_MASK | (WORD_W'(1) << BIT_B);

  always_comb begin
    if (inj_double_i)      word_o = word_i ^ TWO_MASK;
    else if (inj_single_i) word_o = word_i ^ ONE_MASK;
    else                   word_o = word_i;
  end

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = ham_bits(DATA_W),
  parameter int CHK_W  = HAM_W + 1,
  parameter int WORD_W = DATA_W + CHK_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);

  logic [DATA_W-1:0] data_rx;
  logic [HAM_W-1:0]  ham_rx;
  logic [HAM_W-1:0]  ham_calc;
  logic [HAM_W-1:0]  syndrome;
  logic              parity_odd;
  logic              syn_nz;
  logic [DATA_W-1:0] flip;

  assign data_rx = word_i[DATA_W-1:0];
  assign ham_rx  = word_i[DATA_W +: HAM_W];

  for (genvar i = 0; i < HAM_W; i++) begin : g_syn
    localparam logic [255:0] MSK = ham_mask(i, DATA_W);
    assign ham_calc[i] = ^(data_rx & MSK[DATA_W-1:0]);
  end

  assign syndrome   = ham_calc ^ ham_rx;
  assign syn_nz     = |syndrome;
  assign parity_odd = ^word_i;

  for (genvar d = 0; d < DATA_W; d++) begin : g_fix
    localparam int POS = data_pos(d);
    assign flip[d] = parity_odd && (syndrome == HAM_W'(POS));
  end

  assign data_o   = data_rx ^ flip;
  assign single_o = parity_odd;
  assign double_o = syn_nz && !parity_odd;

endmodule

// File: rtl/secded_path.sv
module secded_path
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = ham_bits(DATA_W) + 1,
  parameter int INJ_A  = 0,
  parameter int INJ_B  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enc_en,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [CHK_W-1:0]        ext_check,
  input  logic                    inj_single,
  input  logic                    inj_double,
  output logic [CHK_W-1:0]        check_out,
  output logic [DATA_W+CHK_W-1:0] wr_word,
  input  logic                    dec_en,
  input  logic [DATA_W+CHK_W-1:0] rd_word,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    err_single,
  output logic                    err_double
);

  localparam int HAM_W  = CHK_W - 1;
  localparam int WORD_W = DATA_W + CHK_W;

  // ---------------- write side ----------------
  logic [CHK_W-1:0]  gen_check;
  logic [CHK_W-1:0]  sel_check;
  logic [WORD_W-1:0] clean_word;
  logic [WORD_W-1:0] tx_word;

  secded_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_enc (
    .data_i  (wr_data),
    .check_o (gen_check)
  );

  assign sel_check  = enc_en ? gen_check : ext_check;
  assign clean_word = {sel_check, wr_data};

  secded_injector #(.WORD_W(WORD_W), .BIT_A(INJ_A), .BIT_B(INJ_B)) u_inj (
    .word_i       (clean_word),
    .inj_single_i (inj_single),
    .inj_double_i (inj_double),
    .word_o       (tx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_word   <= '0;
      check_out <= '0;
    end else begin
      wr_word   <= tx_word;
      check_out <= sel_check;
    end
  end

  // ---------------- read side ----------------
  logic [DATA_W-1:0] fix_data;
  logic              fix_single;
  logic              fix_double;

  secded_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W), .WORD_W(WORD_W)) u_dec (
    .word_i   (rd_word),
    .data_o   (fix_data),
    .single_o (fix_single),
    .double_o (fix_double)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      err_single <= 1'b0;
      err_double <= 1'b0;
    end else if (dec_en) begin
      rd_data    <= fix_data;
      err_single <= fix_single;
      err_double <= fix_double;
    end else begin
      rd_data    <= rd_word[DATA_W-1:0];
      err_single <= 1'b0;
      err_double <= 1'b0;
    end
  end

endmodule

// File: rtl/secded_path_chk.sv
module secded_path_chk #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enc_en,
  input logic [DATA_W-1:0]       wr_data,
  input logic [CHK_W-1:0]        ext_check,
  input logic                    inj_single,
  input logic                    inj_double,
  input logic [CHK_W-1:0]        check_out,
  input logic [DATA_W+CHK_W-1:0] wr_word,
  input logic                    dec_en,
  input logic [DATA_W+CHK_W-1:0] rd_word,
  input logic [DATA_W-1:0]       rd_data,
  input logic                    err_single,
  input logic                    err_double
);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !err_single && !err_double && wr_word == '0 && check_out == '0));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(err_single && err_double));

  assert_inject_one_R7: assert property (@(posedge clk) disable iff (rst)
    (inj_single && !inj_double) |=> $countones(wr_word ^ {check_out, $past(wr_data)}) == 1);

  assert_inject_two_R8: assert property (@(posedge clk) disable iff (rst)
    inj_double |=> $countones(wr_word ^ {check_out, $past(wr_data)}) == 2);

  assert_enc_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    !enc_en |=> (check_out == $past(ext_check)));

  assert_dec_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> (rd_data == $past(rd_word[DATA_W-1:0]) && !err_single && !err_double));

endmodule

bind secded_path secded_path_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (.*);

// File: tb/secded_path_tb.sv
module secded_path_tb;

  localparam int DW = 64;
  localparam int CW = 8;
  localparam int WW = DW + CW;

  logic          clk = 1'b0;
  logic          rst;
  logic          enc_en, inj_single, inj_double, dec_en;
  logic [DW-1:0] wr_data, rd_data;
  logic [CW-1:0] ext_check, check_out;
  logic [WW-1:0] wr_word, rd_word;
  logic          err_single, err_double;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  secded_path u_dut (
    .clk(clk), .rst(rst), .enc_en(enc_en), .wr_data(wr_data), .ext_check(ext_check),
    .inj_single(inj_single), .inj_double(inj_double), .check_out(check_out),
    .wr_word(wr_word), .dec_en(dec_en), .rd_word(rd_word), .rd_data(rd_data),
    .err_single(err_single), .err_double(err_double)
  );

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference check field: XOR of codeword positions of the set data bits.
  function automatic logic [CW-1:0] ref_check(input logic [DW-1:0] d);
    logic [6:0] acc;
    int idx;
    acc = '0;
    idx = 0;
    for (int pos = 1; idx < DW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx]) acc = acc ^ 7'(pos);
        idx++;
      end
    end
    return {(^d) ^ (^acc), acc};
  endfunction

  task automatic encode(input logic [DW-1:0] d, input logic [CW-1:0] ext, input logic en,
                        input logic i1, input logic i2, output logic [WW-1:0] w);
    wr_data = d; ext_check = ext; enc_en = en; inj_single = i1; inj_double = i2;
    @(negedge clk);
    w = wr_word;
    enc_en = 1'b1; inj_single = 1'b0; inj_double = 1'b0;
  endtask

  task automatic decode(input logic [WW-1:0] w, input logic en, output logic [DW-1:0] d,
                        output logic s, output logic db);
    rd_word = w; dec_en = en;
    @(negedge clk);
    d = rd_data; s = err_single; db = err_double;
    dec_en = 1'b1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wr_data = '1; ext_check = '1; enc_en = 1'b1; inj_single = 1'b1; inj_double = 1'b0;
    dec_en = 1'b1; rd_word = '1;
    repeat (3) @(negedge clk);
    check(rd_data == '0 && !err_single && !err_double, "R11 read side", WW'(rd_data), '0);
    check(wr_word == '0 && check_out == '0, "R11 write side", wr_word, '0);
    rst = 1'b0; inj_single = 1'b0;
  endtask

  task automatic t_encode_clean;
    logic [DW-1:0] pats [5];
    logic [WW-1:0] w;
    logic [DW-1:0] d;
    logic s, db;
    pats = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0123_4567,
             64'h8000_0000_0000_0001, 64'h0F0F_5A5A_A5A5_F0F0};
    foreach (pats[k]) begin
      encode(pats[k], 8'h00, 1'b1, 1'b0, 1'b0, w);
      check(w == {ref_check(pats[k]), pats[k]}, "R1 encoded word", w, {ref_check(pats[k]), pats[k]});
      check(check_out == w[WW-1:DW], "R2 check_out", WW'(check_out), WW'(w[WW-1:DW]));
      decode(w, 1'b1, d, s, db);
      check(d == pats[k] && !s && !db, "R3 clean read", {6'b0, s, db, d}, WW'(pats[k]));
    end
  endtask

  task automatic t_single_every_bit;
    logic [DW-1:0] base = 64'hC3A5_1E0F_9876_2B4D;
    logic [WW-1:0] w;
    logic [DW-1:0] d;
    logic s, db;
    encode(base, 8'h00, 1'b1, 1'b0, 1'b0, w);
    for (int b = 0; b < WW; b++) begin
      decode(w ^ (WW'(1) << b), 1'b1, d, s, db);
      if (b < DW)
        check(d == base && s && !db, "R4 data bit flip", {6'b0, s, db, d}, {8'b10, base});
      else
        check(d == base && s && !db, "R5 check bit flip", {6'b0, s, db, d}, {8'b10, base});
    end
  endtask

  task automatic t_double;
    logic [DW-1:0] base = 64'h1357_9BDF_2468_ACE0;
    logic [WW-1:0] w, e;
    logic [DW-1:0] d;
    logic s, db;
    int pa [6] = '{0, 5, 63, 64, 71, 10};
    int pb [6] = '{1, 40, 70, 65, 2, 11};
    encode(base, 8'h00, 1'b1, 1'b0, 1'b0, w);
    for (int k = 0; k < 6; k++) begin
      e = w ^ (WW'(1) << pa[k]) ^ (WW'(1) << pb[k]);
      decode(e, 1'b1, d, s, db);
      check(!s && db && d == e[DW-1:0], "R6 double flip", {6'b0, s, db, d}, {8'b01, e[DW-1:0]});
    end
  endtask

  task automatic t_inject;
    logic [DW-1:0] base = 64'hAAAA_5555_0000_FFFF;
    logic [WW-1:0] clean, w, exp;
    logic [DW-1:0] d;
    logic s, db;
    clean = {ref_check(base), base};
    encode(base, 8'h00, 1'b1, 1'b1, 1'b0, w);
    exp = clean ^ WW'(1);
    check(w == exp, "R7 inject single", w, exp);
    decode(w, 1'b1, d, s, db);
    check(d == base && s && !db, "R7 injected single corrected", {6'b0, s, db, d}, {8'b10, base});
    encode(base, 8'h00, 1'b1, 1'b0, 1'b1, w);
    exp = clean ^ WW'(3);
    check(w == exp, "R8 inject double", w, exp);
    decode(w, 1'b1, d, s, db);
    check(!s && db, "R8 injected double detected", {6'b0, s, db, d}, {8'b01, d});
    encode(base, 8'h00, 1'b1, 1'b1, 1'b1, w);
    check(w == exp, "R8 both high picks double", w, exp);
  endtask

  task automatic t_enc_bypass;
    logic [DW-1:0] base = 64'h0102_0304_0506_0708;
    logic [WW-1:0] w;
    encode(base, 8'h5C, 1'b0, 1'b0, 1'b0, w);
    check(w == {8'h5C, base}, "R9 word with external check", w, {8'h5C, base});
    check(check_out == 8'h5C, "R9 check_out external", WW'(check_out), WW'(8'h5C));
  endtask

  task automatic t_dec_bypass;
    logic [DW-1:0] base = 64'hFEDC_BA98_7654_3210;
    logic [WW-1:0] w, e;
    logic [DW-1:0] d;
    logic s, db;
    encode(base, 8'h00, 1'b1, 1'b0, 1'b0, w);
    e = w ^ (WW'(1) << 17);
    decode(e, 1'b0, d, s, db);
    check(d == e[DW-1:0] && !s && !db, "R10 bypass single", {6'b0, s, db, d}, WW'(e[DW-1:0]));
    e = w ^ WW'(6);
    decode(e, 1'b0, d, s, db);
    check(d == e[DW-1:0] && !s && !db, "R10 bypass double", {6'b0, s, db, d}, WW'(e[DW-1:0]));
    decode(e, 1'b1, d, s, db);
    check(!(s && db), "R12 flags exclusive", {6'b0, s, db, d}, {8'b01, d});
  endtask

  initial begin
    t_reset();
    t_encode_clean();
    t_single_every_bit();
    t_double();
    t_inject();
    t_enc_bypass();
    t_dec_bypass();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R3 act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule